// File: doc/BRIEF.md
# Eight-Channel Timer Start Controller

This block holds eight 16-bit timer channels behind one small synchronous register bus. Software starts a channel by writing a 1 into that channel's bit of a write-only start register. The write sets the channel's bit in an enable-status register, and the start bit then clears itself. After that, what the counter does depends on the channel's 2-bit mode field:

- **Interval**: counts down on a shared count-clock strobe.
- **Event**: counts down on its own event strobe.
- **Capture**: counts up on the count-clock strobe.

The start takes effect at different moments. In interval and capture modes nothing happens until the next count-clock strobe, and that strobe only loads the counter. In event mode the counter is loaded on the same edge as the bus write. An event strobe never starts a channel. Once a channel is enabled it stays enabled until reset. A disabled channel keeps its counter frozen.

Register map (5-bit word address, 16-bit data, two byte lanes):

| Address | Register | Access |
|---|---|---|
| 0x00 | Start | write-only, reads 0 |
| 0x01 | Enable-status, bit n = channel n | read-only |
| 0x02 | Mode word | read/write |
| 0x08+n | Data register of channel n | read/write |
| 0x10+n | Counter of channel n | read-only |

Top module: `timer_start_ctl`

## Requirements
- R1: After reset, the enable-status, mode, data and counter registers read 0000h and `tickOut` is 0.
- R2: A write to address 0x00 with `busByteEn[0]`=1 sets enable-status bit n for every n whose `busWdata[n]` is 1. The bit reads back as 1 right after that write edge and stays 1 until reset. Data bits that are 0, and bits 15 to 8, change nothing.
- R3: Reading address 0x00 always returns 0000h.
- R4: Only the low byte lane of the start register has any effect. A start write with `busByteEn[0]`=0 starts no channel. A write with only `busByteEn[0]`=1 starts channels normally.
- R5: In interval mode (mode code 00), the counter is unchanged between the start write and the next `cntTick`. That tick loads the data register into the counter, and each later tick decrements it by 1.
- R6: In interval mode, a `cntTick` that finds the counter at 0000h reloads the data register and raises `tickOut[n]` for exactly one cycle. The counter never goes below 0000h.
- R7: In event mode (mode code 01), the start write loads the data register into the counter on that same edge. Each later `eventIn[n]` strobe decrements the counter, which holds at 0000h. `cntTick` does not change it.
- R8: An `eventIn[n]` strobe on a channel that is not enabled neither sets its enable-status bit nor changes its counter.
- R9: In capture mode (mode code 10), the first `cntTick` after the start write loads 0000h into the counter, and each later tick increments it.
- R10: In capture mode, a `captureIn[n]` strobe on an enabled channel copies the counter into the data register. The next `cntTick` then restarts the count from 0000h, and later ticks count up.
- R11: While enable-status bit n is 0, counter n holds its value and ignores `cntTick`, `eventIn` and `captureIn`.
- R12: The mode word holds channel n's mode in bits [2n+1:2n] and reads back as written. Code 11 behaves as interval mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 5 | Word address for reads and writes |
| busByteEn | input | 2 | Byte-lane write enables, bit 0 = bits 7:0 |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr`, combinational |
| cntTick | input | 1 | Shared count-clock enable strobe |
| eventIn | input | 8 | Per-channel event strobe for event mode |
| captureIn | input | 8 | Per-channel capture strobe for capture mode |
| tickOut | output | 8 | Per-channel one-cycle reload pulse in interval mode |

## Verification
The assertions assume that `cntTick`, `eventIn`, `captureIn` and `busWr` are single-cycle strobes that are never high on two cycles in a row. The single-cycle `tickOut` property depends on this: back-to-back ticks on a channel whose data register is 0000h would reload it on every cycle. The bench drives every strobe through tasks that raise it for one cycle and then hold it low for at least one cycle before the next. It only reads the bus while no write is in progress.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  parameter int CH_COUNT = 8;
  parameter int DATA_W   = 16;
  parameter int ADDR_W   = 5;

  localparam int BYTE_COUNT = DATA_W / 8;
  localparam int MODE_BITS  = 2 * CH_COUNT;
  localparam int IDX_W      = $clog2(CH_COUNT);

  localparam logic [ADDR_W-1:0] ADDR_START  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_MODE   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_DATA   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] ADDR_CNT    = ADDR_W'(16);

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'b00,
    MODE_EVENT    = 2'b01,
    MODE_CAPTURE  = 2'b10,
    MODE_SPARE    = 2'b11
  } chanMode_e;

  // Strobes and state handed from control to datapath
  typedef struct packed {
    logic [CH_COUNT-1:0]   startNow;
    logic [CH_COUNT-1:0]   enable;
    logic [CH_COUNT-1:0]   dataWrSel;
    logic [BYTE_COUNT-1:0] byteEn;
    logic [DATA_W-1:0]     wrData;
    logic [MODE_BITS-1:0]  modeVec;
  } ctlStrobe_t;
endpackage

// File: rtl/tsc_channel.sv
module tsc_channel
  import tsc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  chanMode_e             chMode,
  input  logic                  enable,
  input  logic                  startNow,
  input  logic                  dataWr,
  input  logic [BYTE_COUNT-1:0] byteEn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  cntTick,
  input  logic                  eventStb,
  input  logic                  captureStb,
  output logic [DATA_W-1:0]     dataQ,
  output logic [DATA_W-1:0]     cntQ,
  output logic                  tickQ
);

  // Set by a start (interval/capture) or a capture strobe; the next tick loads
  logic loadPend;
  logic capHit;

  assign capHit = enable && !startNow && captureStb && (chMode == MODE_CAPTURE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ    <= '0;
      cntQ     <= '0;
      tickQ    <= 1'b0;
      loadPend <= 1'b0;
    end else begin
      tickQ <= 1'b0;

      if (capHit) begin
        dataQ <= cntQ;
      end else if (dataWr) begin
        for (int b = 0; b < BYTE_COUNT; b++) begin
          if (byteEn[b]) dataQ[b*8 +: 8] <= wrData[b*8 +: 8];
        end
      end

      if (startNow) begin
        if (chMode == MODE_EVENT) begin
          cntQ     <= dataQ;
          loadPend <= 1'b0;
        end else begin
          loadPend <= 1'b1;
        end
      end else if (enable) begin
        unique case (chMode)
          MODE_EVENT: begin
            if (eventStb && (cntQ != '0)) cntQ <= cntQ - DATA_W'(1);
          end
          MODE_CAPTURE: begin
            if (capHit) begin
              loadPend <= 1'b1;
            end else if (cntTick) begin
              if (loadPend) begin
                cntQ     <= '0;
                loadPend <= 1'b0;
              end else begin
                cntQ <= cntQ + DATA_W'(1);
              end
            end
          end
          MODE_INTERVAL, MODE_SPARE: begin
            if (cntTick) begin
              if (loadPend) begin
                cntQ     <= dataQ;
                loadPend <= 1'b0;
              end else if (cntQ == '0) begin
                cntQ  <= dataQ;
                tickQ <= 1'b1;
              end else begin
                cntQ <= cntQ - DATA_W'(1);
              end
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  ctlStrobe_t                        ctl,
  input  logic                              cntTick,
  input  logic [CH_COUNT-1:0]               eventIn,
  input  logic [CH_COUNT-1:0]               captureIn,
  output logic [CH_COUNT-1:0][DATA_W-1:0]   dataVec,
  output logic [CH_COUNT-1:0][DATA_W-1:0]   cntVec,
  output logic [CH_COUNT-1:0]               tickOut
);

  for (genvar n = 0; n < CH_COUNT; n++) begin : g_chan
    tsc_channel u_chan (
      .clk        (clk),
      .rstN       (rstN),
      .chMode     (chanMode_e'(ctl.modeVec[2*n +: 2])),
      .enable     (ctl.enable[n]),
      .startNow   (ctl.startNow[n]),
      .dataWr     (ctl.dataWrSel[n]),
      .byteEn     (ctl.byteEn),
      .wrData     (ctl.wrData),
      .cntTick    (cntTick),
      .eventStb   (eventIn[n]),
      .captureStb (captureIn[n]),
      .dataQ      (dataVec[n]),
      .cntQ       (cntVec[n]),
      .tickQ      (tickOut[n])
    );
  end

endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busWr,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [BYTE_COUNT-1:0]             busByteEn,
  input  logic [DATA_W-1:0]                 busWdata,
  input  logic [CH_COUNT-1:0][DATA_W-1:0]   dataVec,
  input  logic [CH_COUNT-1:0][DATA_W-1:0]   cntVec,
  output logic [DATA_W-1:0]                 busRdata,
  output ctlStrobe_t                        ctl,
  output logic [CH_COUNT-1:0]               startQ,
  output logic [CH_COUNT-1:0]               enableQ
);

  logic [MODE_BITS-1:0] modeQ;
  logic [CH_COUNT-1:0]  startNow;
  logic [CH_COUNT-1:0]  dataWrSel;
  logic                 startSel;
  logic                 modeSel;

  assign startSel = busWr && (busAddr == ADDR_START);
  assign modeSel  = busWr && (busAddr == ADDR_MODE);
  // Only the low byte lane carries start bits; the upper byte is reserved
  assign startNow = (startSel && busByteEn[0]) ? busWdata[CH_COUNT-1:0] : '0;

  always_comb begin
    for (int n = 0; n < CH_COUNT; n++) begin
      dataWrSel[n] = busWr && (busAddr == (ADDR_DATA + ADDR_W'(n)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ  <= '0;
      enableQ <= '0;
      modeQ   <= '0;
    end else begin
      // A start bit drops once its channel reads as enabled
      startQ  <= (startQ & ~enableQ) | startNow;
      enableQ <= enableQ | startNow;
      if (modeSel) begin
        for (int b = 0; b < MODE_BITS / 8; b++) begin
          if (busByteEn[b]) modeQ[b*8 +: 8] <= busWdata[b*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_STATUS) begin
      busRdata[CH_COUNT-1:0] = enableQ;
    end else if (busAddr == ADDR_MODE) begin
      busRdata[MODE_BITS-1:0] = modeQ;
    end else if (busAddr[ADDR_W-1:IDX_W] == ADDR_DATA[ADDR_W-1:IDX_W]) begin
      busRdata = dataVec[busAddr[IDX_W-1:0]];
    end else if (busAddr[ADDR_W-1:IDX_W] == ADDR_CNT[ADDR_W-1:IDX_W]) begin
      busRdata = cntVec[busAddr[IDX_W-1:0]];
    end
  end

  assign ctl.startNow  = startNow;
  assign ctl.enable    = enableQ;
  assign ctl.dataWrSel = dataWrSel;
  assign ctl.byteEn    = busByteEn;
  assign ctl.wrData    = busWdata;
  assign ctl.modeVec   = modeQ;

endmodule

// File: rtl/timer_start_ctl.sv
module timer_start_ctl
  import tsc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWr,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [BYTE_COUNT-1:0] busByteEn,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic                  cntTick,
  input  logic [CH_COUNT-1:0]   eventIn,
  input  logic [CH_COUNT-1:0]   captureIn,
  output logic [CH_COUNT-1:0]   tickOut
);

  ctlStrobe_t                      ctl;
  logic [CH_COUNT-1:0]             startQ;
  logic [CH_COUNT-1:0]             enableQ;
  logic [CH_COUNT-1:0][DATA_W-1:0] dataVec;
  logic [CH_COUNT-1:0][DATA_W-1:0] cntVec;

  tsc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .busWdata  (busWdata),
    .dataVec   (dataVec),
    .cntVec    (cntVec),
    .busRdata  (busRdata),
    .ctl       (ctl),
    .startQ    (startQ),
    .enableQ   (enableQ)
  );

  tsc_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cntTick   (cntTick),
    .eventIn   (eventIn),
    .captureIn (captureIn),
    .dataVec   (dataVec),
    .cntVec    (cntVec),
    .tickOut   (tickOut)
  );

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
  import tsc_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input logic                            busWr,
  input logic [ADDR_W-1:0]               busAddr,
  input logic [DATA_W-1:0]               busRdata,
  input logic [CH_COUNT-1:0]             startQ,
  input logic [CH_COUNT-1:0]             enableQ,
  input logic [CH_COUNT-1:0]             eventIn,
  input logic [CH_COUNT-1:0]             tickOut,
  input logic [CH_COUNT-1:0][DATA_W-1:0] cntVec
);

  assert_start_reads_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_START) |-> (busRdata == '0));

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ != '0) |=> ((enableQ & $past(enableQ)) == $past(enableQ)));

  assert_start_implies_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startQ != '0) |-> ((enableQ & startQ) == startQ));

  assert_start_selfclear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busWr && (startQ != '0)) |=> (startQ == '0));

  assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tickOut != '0) |=> (tickOut == '0));

  assert_event_no_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busWr && ((eventIn & ~enableQ) != '0)) |=> ((enableQ & $past(eventIn & ~enableQ)) == '0));

  for (genvar n = 0; n < CH_COUNT; n++) begin : g_hold
    assert_disabled_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
      (!enableQ[n] && !busWr) |=> $stable(cntVec[n]));
  end

endmodule

bind timer_start_ctl tsc_checker i_tsc_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .startQ   (startQ),
  .enableQ  (enableQ),
  .eventIn  (eventIn),
  .tickOut  (tickOut),
  .cntVec   (cntVec)
);

// File: tb/test_timer_start_ctl.sv
module test_timer_start_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWr;
  logic [4:0]  busAddr;
  logic [1:0]  busByteEn;
  logic [15:0] busWdata;
  logic [15:0] busRdata;
  logic        cntTick;
  logic [7:0]  eventIn;
  logic [7:0]  captureIn;
  logic [7:0]  tickOut;

  int   testCount = 0;
  int   failCount = 0;
  bit   finished  = 0;
  logic [7:0] lastTick;

  timer_start_ctl i_timer_start_ctl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busByteEn(busByteEn), .busWdata(busWdata), .busRdata(busRdata),
    .cntTick(cntTick), .eventIn(eventIn), .captureIn(captureIn), .tickOut(tickOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic readReg(input logic [4:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic checkReg(input string req, input string what, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] d;
    readReg(a, d);
    check(req, what, d, exp);
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d; busByteEn = be;
    @(negedge clk);
    busWr = 1'b0; busByteEn = 2'b00;
  endtask

  task automatic pulseTick();
    @(negedge clk); cntTick = 1'b1;
    @(negedge clk); cntTick = 1'b0;
    lastTick = tickOut;
  endtask

  task automatic pulseEvent(input logic [7:0] m);
    @(negedge clk); eventIn = m;
    @(negedge clk); eventIn = '0;
  endtask

  task automatic pulseCapture(input logic [7:0] m);
    @(negedge clk); captureIn = m;
    @(negedge clk); captureIn = '0;
  endtask

  task automatic testReset();
    checkReg("R1", "status", 5'h01, 16'h0000);
    checkReg("R1", "mode", 5'h02, 16'h0000);
    checkReg("R1", "data0", 5'h08, 16'h0000);
    checkReg("R1", "cnt7", 5'h17, 16'h0000);
    check("R1", "tickOut", {8'h00, tickOut}, 16'h0000);
    checkReg("R3", "start read", 5'h00, 16'h0000);
  endtask

  task automatic testStartMasking();
    busWrite(5'h00, 16'h0000, 2'b11);
    checkReg("R2", "zero bits no start", 5'h01, 16'h0000);
    busWrite(5'h00, 16'hFF00, 2'b11);
    checkReg("R2", "reserved byte no start", 5'h01, 16'h0000);
    busWrite(5'h00, 16'hFFFF, 2'b10);
    checkReg("R4", "upper lane only no start", 5'h01, 16'h0000);
  endtask

  task automatic testModeMap();
    // ch1 event, ch2 capture, ch4 event, ch5 code 11, others interval
    busWrite(5'h02, 16'h0D24, 2'b11);
    checkReg("R12", "mode readback", 5'h02, 16'h0D24);
  endtask

  task automatic testInterval();
    busWrite(5'h08, 16'h0003, 2'b11);
    busWrite(5'h00, 16'h0001, 2'b01);
    checkReg("R2", "ch0 enabled", 5'h01, 16'h0001);
    checkReg("R3", "start reads 0 after write", 5'h00, 16'h0000);
    checkReg("R5", "ch0 idle before tick", 5'h10, 16'h0000);
    pulseTick();
    checkReg("R5", "ch0 first tick loads", 5'h10, 16'h0003);
    pulseTick();
    checkReg("R5", "ch0 decrement", 5'h10, 16'h0002);
    pulseTick();
    pulseTick();
    checkReg("R6", "ch0 at zero", 5'h10, 16'h0000);
    check("R6", "no tick on reaching zero", {8'h00, lastTick}, 16'h0000);
    pulseTick();
    checkReg("R6", "ch0 reload", 5'h10, 16'h0003);
    check("R6", "tick pulse", {15'h0, lastTick[0]}, 16'h0001);
    pulseTick();
    checkReg("R6", "ch0 after reload", 5'h10, 16'h0002);
    check("R6", "tick dropped", {15'h0, lastTick[0]}, 16'h0000);
  endtask

  task automatic testEvent();
    busWrite(5'h09, 16'h0005, 2'b11);
    pulseEvent(8'h02);
    checkReg("R8", "ch1 not started by event", 5'h01, 16'h0001);
    checkReg("R8", "ch1 counter held", 5'h11, 16'h0000);
    busWrite(5'h00, 16'h0002, 2'b01);
    checkReg("R7", "ch1 loaded at write", 5'h11, 16'h0005);
    pulseTick();
    checkReg("R7", "ch1 ignores tick", 5'h11, 16'h0005);
    pulseEvent(8'h02);
    pulseEvent(8'h02);
    checkReg("R7", "ch1 decrement", 5'h11, 16'h0003);
    for (int i = 0; i < 4; i++) pulseEvent(8'h02);
    checkReg("R7", "ch1 holds at zero", 5'h11, 16'h0000);
  endtask

  task automatic testCapture();
    busWrite(5'h00, 16'h0004, 2'b01);
    checkReg("R9", "ch2 idle before tick", 5'h12, 16'h0000);
    pulseTick();
    checkReg("R9", "ch2 first tick loads zero", 5'h12, 16'h0000);
    pulseTick();
    pulseTick();
    pulseTick();
    checkReg("R9", "ch2 counts up", 5'h12, 16'h0003);
    pulseCapture(8'h04);
    checkReg("R10", "ch2 captured", 5'h0A, 16'h0003);
    checkReg("R10", "ch2 counter held", 5'h12, 16'h0003);
    pulseTick();
    checkReg("R10", "ch2 restart at zero", 5'h12, 16'h0000);
    pulseTick();
    checkReg("R10", "ch2 counts after restart", 5'h12, 16'h0001);
  endtask

  task automatic testDisabled();
    busWrite(5'h0B, 16'h0007, 2'b11);
    busWrite(5'h0C, 16'h0009, 2'b11);
    pulseTick();
    pulseEvent(8'h18);
    pulseCapture(8'h08);
    checkReg("R11", "ch3 counter held", 5'h13, 16'h0000);
    checkReg("R8", "ch4 counter held", 5'h14, 16'h0000);
    checkReg("R8", "ch3/ch4 not enabled", 5'h01, 16'h0007);
  endtask

  task automatic testSpareMode();
    busWrite(5'h0D, 16'h0002, 2'b11);
    busWrite(5'h00, 16'h0020, 2'b01);
    checkReg("R12", "ch5 idle before tick", 5'h15, 16'h0000);
    pulseTick();
    checkReg("R12", "ch5 loads like interval", 5'h15, 16'h0002);
    pulseTick();
    checkReg("R12", "ch5 counts down", 5'h15, 16'h0001);
    checkReg("R2", "final status", 5'h01, 16'h0027);
    checkReg("R3", "start reads 0 at end", 5'h00, 16'h0000);
  endtask

  initial begin
    rstN = 1'b0; busWr = 1'b0; busAddr = '0; busByteEn = '0; busWdata = '0;
    cntTick = 1'b0; eventIn = '0; captureIn = '0; lastTick = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStartMasking();
    testModeMap();
    testInterval();
    testEvent();
    testCapture();
    testDisabled();
    testSpareMode();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule